// File: doc/BRIEF.md
# Modem Line Status and Control Unit

This unit holds the modem-side register pair of a serial port. One register drives four outgoing handshake lines (request-to-send, terminal-ready and two general-purpose outputs) and a loopback switch. The other reports the current level of four incoming handshake lines (carrier, ring, set-ready, clear-to-send), together with sticky change flags. The change flags remain set until software reads the status.

The incoming lines are asynchronous, so each one passes through a two-flop synchronizer. The synchronized levels are then compared with the levels stored in the status register. Any difference raises the matching change flag. The ring line is the exception: it only flags a change when it falls. When loopback is set, the external outputs are held inactive and the external inputs are ignored. In that mode a status read reports the unit's own control outputs in place of the line levels. A modem interrupt request is raised whenever the interrupt enable input is high and any change flag is set.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status read value is 0xB0 (carrier bit 7, set-ready bit 5 and clear-to-send bit 4 set; ring bit 6 and all flags clear). `out2_out` is 1, `rts_out`, `dtr_out` and `out1_out` are 0, and `msi_irq` is 0.
- R2: Status bits 7..4 hold carrier, ring, set-ready and clear-to-send. Each follows its input line three clock edges after the line changes: two synchronizer stages and the status register.
- R3: A change of carrier, set-ready or clear-to-send sets flag bit 3, bit 1 or bit 0 respectively. Flags are sticky: a line that toggles away and back before a read still leaves its flag set.
- R4: Flag bit 2 is set only when the ring line falls from 1 to 0. A rise of the ring line sets no flag.
- R5: A status read (`sts_rd` high) returns the register value in the same cycle. At the next edge it clears bits 3..0 and keeps bits 7..4.
- R6: A control write (`ctl_wr` high) stores `ctl_wdata[4:0]` and ignores bits 7..5. The bit assignment is: terminal-ready bit 0, request-to-send bit 1, output-1 bit 2, output-2 bit 3, loopback bit 4. When loopback is clear, the four stored output bits drive their output pins.
- R7: While loopback is set, all four output pins are 0. A status read then returns output-2 in bit 7, output-1 in bit 6, terminal-ready in bit 5, request-to-send in bit 4, and 0 in bits 3..0.
- R8: While loopback is set, the stored status and flags do not change: external line changes are ignored and reads clear nothing. When loopback is cleared, any difference between the lines and the stored levels is flagged per R3 and R4.
- R9: `msi_irq` is high exactly when `msi_en` is high and at least one of status bits 3..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| ri_in | input | 1 | Ring line, asynchronous |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| sts_rd | input | 1 | Status register read strobe (clears flags) |
| msi_en | input | 1 | Modem interrupt enable |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Terminal-ready output |
| out1_out | output | 1 | General-purpose output 1 |
| out2_out | output | 1 | General-purpose output 2 |
| sts_rdata | output | 8 | Status register read value |
| msi_irq | output | 1 | Modem interrupt request |

## Verification
The bench moves the ring line in both directions. A design that flags the rise would show bit 2 after the ring line asserts, and one that used a plain XOR flag would report a change for either edge. The bench toggles a line away and back with no read in between, which catches a design that recomputes the flags instead of latching them. It also enters loopback and moves the external lines there, which exposes designs that pass external levels through or drop the change on leaving loopback. Control writes with the upper data bits set catch a design that lets bits 7..5 reach any output.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  // Number of handshake input lines and their packed order {dcd, ri, dsr, cts}
  localparam int unsigned NLINES    = 4;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned STS_W     = 2 * NLINES;
  localparam int unsigned CTL_W     = 5;

  // Nibble positions inside the line vector; flag bits mirror them
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_RI  = 2;
  localparam int unsigned L_DCD = 3;

  // Control register fields
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_OUT1 = 2;
  localparam int unsigned C_OUT2 = 3;
  localparam int unsigned C_LOOP = 4;

  localparam logic [NLINES-1:0] LINES_RST = 4'b1011;
  localparam logic [STS_W-1:0]  STS_RST   = {LINES_RST, {NLINES{1'b0}}};
  localparam logic [CTL_W-1:0]  CTL_RST   = 5'b01000;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_async;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/mstat_status.sv
module mstat_status
  import mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_s,
  input  logic              loop_en,
  input  logic              rd_req,
  output logic [STS_W-1:0]  sts_q
);
  logic [NLINES-1:0] chg, flag_new, flag_keep;
  logic [STS_W-1:0]  sts_d;
  logic              sts_en;

  always_comb begin
    chg       = lines_s ^ sts_q[STS_W-1:NLINES];
    flag_new  = chg;
    flag_new[L_RI] = chg[L_RI] & ~lines_s[L_RI];   // falling ring edge only
    flag_keep = rd_req ? '0 : sts_q[NLINES-1:0];
    sts_d     = {lines_s, flag_keep | flag_new};
    sts_en    = ~loop_en;                           // frozen in loopback
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= STS_RST;
    else if (sts_en) sts_q <= sts_d;
  end

  AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_q[L_RI] ##1 sts_q[L_RI]) |-> ($past(sts_q[NLINES+L_RI]) && !sts_q[NLINES+L_RI])); // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> ((sts_q[NLINES-1:0] & $past(sts_q[NLINES-1:0])) == $past(sts_q[NLINES-1:0]))); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !loop_en && (lines_s == sts_q[STS_W-1:NLINES])) |=> (sts_q[NLINES-1:0] == '0)); // R5

  AST_LOOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> $stable(sts_q)); // R8
endmodule

// File: rtl/mstat_ctrl.sv
module mstat_ctrl
  import mstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             rts_o,
  output logic             dtr_o,
  output logic             out1_o,
  output logic             out2_o
);
  logic [CTL_W-1:0] ctl_d;
  logic             unused_hi;

  assign unused_hi = ^wdata[7:CTL_W];

  always_comb begin
    ctl_d = wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CTL_RST;
    else if (wr_en) ctl_q <= ctl_d;
  end

  always_comb begin
    rts_o  = ctl_q[C_RTS]  & ~ctl_q[C_LOOP];
    dtr_o  = ctl_q[C_DTR]  & ~ctl_q[C_LOOP];
    out1_o = ctl_q[C_OUT1] & ~ctl_q[C_LOOP];
    out2_o = ctl_q[C_OUT2] & ~ctl_q[C_LOOP];
  end

  AST_WRITE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == $past(wdata[CTL_W-1:0]))); // R6

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q)); // R6
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import mstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       dcd_in,
  input  logic       ri_in,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       sts_rd,
  input  logic       msi_en,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       out1_out,
  output logic       out2_out,
  output logic [7:0] sts_rdata,
  output logic       msi_irq
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [NLINES-1:0] lines_raw, lines_s;
  logic [CTL_W-1:0]  ctl_q;
  logic [STS_W-1:0]  sts_q;
  logic              loop_en;
  logic [NLINES-1:0] loop_nib;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    lines_raw        = '0;
    lines_raw[L_CTS] = cts_in;
    lines_raw[L_DSR] = dsr_in;
    lines_raw[L_RI]  = ri_in;
    lines_raw[L_DCD] = dcd_in;
  end

  mstat_sync #(.WIDTH(NLINES), .STAGES(SYNC_DEPTH), .RST_VAL(LINES_RST)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(lines_raw), .q_sync(lines_s));

  mstat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .wr_en(ctl_wr), .wdata(ctl_wdata),
    .ctl_q(ctl_q), .rts_o(rts_out), .dtr_o(dtr_out),
    .out1_o(out1_out), .out2_o(out2_out));

  assign loop_en = ctl_q[C_LOOP];

  mstat_status u_status (
    .clk(clk), .rst_n(rst_int_n), .lines_s(lines_s), .loop_en(loop_en),
    .rd_req(sts_rd), .sts_q(sts_q));

  always_comb begin
    loop_nib        = '0;
    loop_nib[L_DCD] = ctl_q[C_OUT2];
    loop_nib[L_RI]  = ctl_q[C_OUT1];
    loop_nib[L_DSR] = ctl_q[C_DTR];
    loop_nib[L_CTS] = ctl_q[C_RTS];
    sts_rdata = loop_en ? {loop_nib, {NLINES{1'b0}}} : sts_q;
    msi_irq   = msi_en & (|sts_q[NLINES-1:0]);
  end

  AST_LOOP_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    loop_en |-> !(rts_out | dtr_out | out1_out | out2_out)); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    msi_irq |-> (msi_en && sts_q[NLINES-1:0] != '0)); // R9
endmodule

// File: tb/sim_modem_status_unit.sv
`timescale 1ns/1ps
module sim_modem_status_unit;
  logic clk = 1'b0;
  logic rst_n, cts_in, dsr_in, dcd_in, ri_in, ctl_wr, sts_rd, msi_en;
  logic [7:0] ctl_wdata, sts_rdata;
  logic rts_out, dtr_out, out1_out, out2_out, msi_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  modem_status_unit u0 (.*);

  // {dcd, ri, dsr, cts} applied, then expected status read value
  localparam logic [11:0] VEC [0:7] = '{
    12'hBB0, 12'hAA1, 12'h882, 12'hCC0, 12'h884, 12'h008, 12'hFFB, 12'hBB4};

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic set_lines(input logic [3:0] n);
    @(negedge clk);
    {dcd_in, ri_in, dsr_in, cts_in} = n;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string req);
    sts_rd = 1'b1;
    #1 chk(sts_rdata === exp, req, sts_rdata, exp);
    @(negedge clk);
    sts_rd = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {4'h0, out2_out, out1_out, rts_out, dtr_out};
  endfunction

  initial begin
    rst_n = 0; {dcd_in, ri_in, dsr_in, cts_in} = 4'b1011;
    ctl_wr = 0; ctl_wdata = 0; sts_rd = 0; msi_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(outs() == 8'h08, "R1 outputs", outs(), 8'h08);
    chk(msi_irq == 1'b0, "R1 irq", {7'h0, msi_irq}, 8'h00);
    rd_chk(8'hB0, "R1 status");

    // R2 R3 R4 R5 table of line patterns, each followed by a clearing read
    for (int i = 0; i < 8; i++) begin
      set_lines(VEC[i][11:8]);
      rd_chk(VEC[i][7:0], "R2/R3/R4 vector");
    end
    rd_chk(8'hB0, "R5 flags cleared, levels kept");

    // R3 sticky flag across toggle-and-return
    set_lines(4'b1010);
    set_lines(4'b1011);
    chk(msi_irq == 1'b0, "R9 irq masked", {7'h0, msi_irq}, 8'h00);
    msi_en = 1'b1;
    #1 chk(msi_irq == 1'b1, "R9 irq raised", {7'h0, msi_irq}, 8'h01);
    rd_chk(8'hB1, "R3 sticky flag");
    chk(msi_irq == 1'b0, "R9 irq after read", {7'h0, msi_irq}, 8'h00);
    rd_chk(8'hB0, "R5 second read");

    // R6 control writes, upper data bits ignored
    wr_ctl(8'hEF);
    chk(outs() == 8'h0F, "R6 all outputs", outs(), 8'h0F);
    wr_ctl(8'hE5);
    chk(outs() == 8'h05, "R6 dtr and out1", outs(), 8'h05);

    // R7 loopback routing
    wr_ctl(8'h15);
    chk(outs() == 8'h00, "R7 pins quiet", outs(), 8'h00);
    rd_chk(8'h60, "R7 loop read a");
    wr_ctl(8'h1A);
    rd_chk(8'h90, "R7 loop read b");

    // R8 external lines ignored in loopback, reported on exit
    set_lines(4'b1010);
    chk(msi_irq == 1'b0, "R8 no irq in loopback", {7'h0, msi_irq}, 8'h00);
    rd_chk(8'h90, "R8 loop read unchanged");
    wr_ctl(8'h08);
    @(negedge clk);
    chk(out2_out == 1'b1, "R6 out2 after loop exit", {7'h0, out2_out}, 8'h01);
    chk(msi_irq == 1'b1, "R9 irq after loop exit", {7'h0, msi_irq}, 8'h01);
    rd_chk(8'hA1, "R8 change flagged on exit");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule